// File: doc/BRIEF.md
# Timer Count Readout Latch

This block is the read side of one channel of a 16-bit interval timer. It keeps a two-byte output latch that tracks the live value of the channel's down-counter. When a latch command arrives, the latch freezes the value present at that clock edge. The block then returns that value over an 8-bit read bus in the byte format the channel was programmed with. When the last byte of the frozen value has been read, the latch releases itself and goes back to tracking the counter.

The counter itself is never read directly; every byte comes through the latch. A byte pointer picks the low or the high half for each read. In the two-byte format the pointer steps after each read. The pointer moves only on reads of this channel, so a write path elsewhere may interleave writes with reads freely. When this channel is not being read, its data output is zero, so several channels' outputs can be ORed onto one bus.

Top module: `tmr_rd_latch`

## Requirements
- R1: While not latched, a read of the channel returns, in the same cycle, the selected byte of the current `live_cnt`.
- R2: A latch command captures `live_cnt` at that clock edge. Reads after that edge return bytes of the captured value, even when `live_cnt` changes.
- R3: A latch command that arrives while a value is already held and unread has no effect. The value read is the one captured first.
- R4: The latch releases on the edge that ends the final read. In format 2'b11 that is the high-byte read; in every other format it is any read. The next read returns the live count.
- R5: The format code `acc_fmt` has these meanings. 2'b01 means low byte only. 2'b10 means high byte only. 2'b11 means low byte then high byte, with the pointer toggling on each read. Code 2'b00 is treated as low byte only. In a single-byte format the pointer stays on the first byte.
- R6: A cycle with `rd_en` high and `rd_sel` low (a read of another channel) neither moves the pointer nor releases the latch.
- R7: `reprog` clears any held value and returns the pointer to the low byte. When it coincides with a latch command, `reprog` wins and nothing is held.
- R8: When a latch command coincides with the final read of a held value, that read returns the old held byte and the latch captures the live count at that edge.
- R9: When `rd_en` and `rd_sel` are not both high, `rd_data` is zero.
- R10: A latch command does not move the byte pointer. A latch taken between the two reads of a two-byte sequence is read starting from the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_cnt | input | 16 | Current value of the channel's counting element |
| latch_cmd | input | 1 | One-cycle strobe: freeze the count |
| acc_fmt | input | 2 | Programmed byte access format (R5 encoding) |
| reprog | input | 1 | One-cycle strobe: channel was reprogrammed |
| rd_en | input | 1 | Read strobe on the shared bus |
| rd_sel | input | 1 | This channel is the one addressed by the read |
| rd_data | output | 8 | Read data byte, zero when not addressed |

## Verification
Two functions can fall in the same cycle: the final read that releases a held value, and a fresh latch command. Reprogramming can also coincide with a latch command. The bench provokes the first case by raising `latch_cmd` on the cycle of the high-byte read. It judges the result by checking two things: that read still shows the old held byte, and the next low-byte read shows the count captured at that edge, not the live value. For the reprogram case it checks that the following read returns the live count.

// File: rtl/tmr_rd_pkg.sv
package tmr_rd_pkg;

  typedef enum logic [1:0] {
    FMT_NONE = 2'b00,
    FMT_LO   = 2'b01,
    FMT_HI   = 2'b10,
    FMT_LOHI = 2'b11
  } acc_fmt_e;

  // A read ends the sequence unless it is the low half of a two-byte access
  function automatic logic last_byte(input logic [1:0] fmt, input logic ptr);
    return (fmt != FMT_LOHI) || ptr;
  endfunction

  // Which half a read presents: 1 means the high byte
  function automatic logic high_half(input logic [1:0] fmt, input logic ptr);
    return (fmt == FMT_HI) || ((fmt == FMT_LOHI) && ptr);
  endfunction

endpackage

// File: rtl/rd_ptr_ctl.sv
module rd_ptr_ctl
  import tmr_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_hit,
  input  logic [1:0] fmt,
  input  logic       reprog,
  output logic       ptr_q,
  output logic       final_rd,
  output logic       hi_sel
);

  always_comb begin
    final_rd = rd_hit && last_byte(fmt, ptr_q);
    hi_sel   = high_half(fmt, ptr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             ptr_q <= 1'b0;
    else if (reprog)                        ptr_q <= 1'b0;
    else if (rd_hit && (fmt == FMT_LOHI))   ptr_q <= ~ptr_q;
  end

  AST_REPROG_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    reprog |=> !ptr_q); // R7

  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hit && !reprog) |=> $stable(ptr_q)); // R6

  AST_PTR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !reprog && fmt != FMT_LOHI) |=> ptr_q == $past(ptr_q)); // R5

endmodule

// File: rtl/ol_hold.sv
module ol_hold #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] live,
  input  logic             latch_cmd,
  input  logic             final_rd,
  input  logic             reprog,
  output logic [CNT_W-1:0] ol_val,
  output logic             held_q
);

  logic [CNT_W-1:0] hold_q;
  logic             take;

  // Capture when nothing is held, or when the held value is consumed this cycle
  assign take   = latch_cmd && !reprog && (!held_q || final_rd);
  assign ol_val = held_q ? hold_q : live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      hold_q <= '0;
    end else if (reprog) begin
      held_q <= 1'b0;
    end else if (take) begin
      held_q <= 1'b1;
      hold_q <= live;
    end else if (final_rd) begin
      held_q <= 1'b0;
    end
  end

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_cmd && !reprog && !held_q) |=> held_q && ol_val == $past(live)); // R2

  AST_SECOND_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !final_rd && !reprog) |=> held_q && $stable(ol_val)); // R3

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && final_rd && !latch_cmd && !reprog) |=> !held_q); // R4

  AST_REPROG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    reprog |=> !held_q); // R7

endmodule

// File: rtl/rd_mux.sv
module rd_mux #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic [CNT_W-1:0]  ol_val,
  input  logic              hi_sel,
  input  logic              rd_hit,
  output logic [BYTE_W-1:0] rd_data
);

  always_comb begin
    rd_data = '0;
    if (rd_hit) rd_data = hi_sel ? ol_val[CNT_W-1:BYTE_W] : ol_val[BYTE_W-1:0];
  end

endmodule

// File: rtl/tmr_rd_latch.sv
module tmr_rd_latch #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              latch_cmd,
  input  logic [1:0]        acc_fmt,
  input  logic              reprog,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [BYTE_W-1:0] rd_data
);

  logic             rd_hit;
  logic             ptr_q;
  logic             final_rd;
  logic             hi_sel;
  logic             held_q;
  logic [CNT_W-1:0] ol_val;

  assign rd_hit = rd_en && rd_sel;

  rd_ptr_ctl u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_hit   (rd_hit),
    .fmt      (acc_fmt),
    .reprog   (reprog),
    .ptr_q    (ptr_q),
    .final_rd (final_rd),
    .hi_sel   (hi_sel)
  );

  ol_hold #(.CNT_W(CNT_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .live      (live_cnt),
    .latch_cmd (latch_cmd),
    .final_rd  (final_rd),
    .reprog    (reprog),
    .ol_val    (ol_val),
    .held_q    (held_q)
  );

  rd_mux #(.BYTE_W(BYTE_W)) u_mux (
    .ol_val  (ol_val),
    .hi_sel  (hi_sel),
    .rd_hit  (rd_hit),
    .rd_data (rd_data)
  );

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> rd_data == '0); // R9

  AST_LATCH_NO_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_cmd && !rd_hit && !reprog) |=> ptr_q == $past(ptr_q)); // R10

  AST_COINCIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && final_rd && latch_cmd && !reprog) |=> held_q && ol_val == $past(live_cnt)); // R8

endmodule

// File: tb/tb_tmr_rd_latch.sv
`timescale 1ns/1ps
module tb_tmr_rd_latch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] live_cnt = 16'h0;
  logic        latch_cmd = 1'b0;
  logic [1:0]  acc_fmt = 2'b11;
  logic        reprog = 1'b0;
  logic        rd_en = 1'b0;
  logic        rd_sel = 1'b0;
  logic [7:0]  rd_data;

  int total = 0;
  int bad = 0;

  // behavioural reference state
  int m_held = 0;
  int m_hold = 0;
  int m_ptr = 0;

  always #2.5 clk = ~clk;

  tmr_rd_latch dut (
    .clk(clk), .rst_n(rst_n), .live_cnt(live_cnt), .latch_cmd(latch_cmd),
    .acc_fmt(acc_fmt), .reprog(reprog), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data)
  );

  function automatic int expect_byte();
    int val, hi;
    if (!(rd_en && rd_sel)) return 0;
    val = m_held ? m_hold : int'(live_cnt);
    if (acc_fmt == 2'b10) hi = 1;
    else if (acc_fmt == 2'b11) hi = m_ptr;
    else hi = 0;
    return hi ? (val / 256) % 256 : val % 256;
  endfunction

  // one cycle: drive at negedge, check combinational output, advance model at posedge
  task automatic step(input logic r, input logic s, input logic l, input logic p,
                      input logic [1:0] f, input logic [15:0] live, input string tag);
    int exp, fin;
    rd_en = r; rd_sel = s; latch_cmd = l; reprog = p; acc_fmt = f; live_cnt = live;
    #1;
    exp = expect_byte();
    total++;
    if (int'(rd_data) != exp) begin
      bad++;
      $display("FAIL %s: rd_data=%02h expected=%02h", tag, rd_data, exp);
    end
    @(posedge clk);
    fin = (r && s) && (f != 2'b11 || m_ptr == 1);
    if (p) begin
      m_held = 0; m_ptr = 0;
    end else begin
      if (r && s && f == 2'b11) m_ptr = 1 - m_ptr;
      if (l && (!m_held || fin)) begin
        m_held = 1; m_hold = int'(live);
      end else if (fin) m_held = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state: zero output while held in reset, idle after
    total++;
    if (rd_data !== 8'h00) begin
      bad++; $display("FAIL R9 reset: rd_data=%02h expected=00", rd_data);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 unlatched two-byte reads follow live count
    step(1,1,0,0,2'b11,16'h1234,"R1 lo");
    step(1,1,0,0,2'b11,16'h5678,"R1 hi");
    step(0,0,0,0,2'b11,16'h9abc,"R9 idle");
    // R2 latch then read while live moves
    step(0,0,1,0,2'b11,16'hA1B2,"R2 latch");
    step(1,1,0,0,2'b11,16'h0001,"R2 lo");
    step(0,0,0,0,2'b11,16'h0002,"R2 gap");
    step(1,1,0,0,2'b11,16'h0003,"R2 hi");
    // R4 released
    step(1,1,0,0,2'b11,16'hC0DE,"R4 lo live");
    step(1,1,0,0,2'b11,16'hBEEF,"R4 hi live");
    // R3 second latch ignored
    step(0,0,1,0,2'b11,16'h1111,"R3 first");
    step(0,0,1,0,2'b11,16'h2222,"R3 second");
    step(1,1,1,0,2'b11,16'h3333,"R3 lo");
    step(1,1,0,0,2'b11,16'h4444,"R3 hi");
    // R6 other channel read between the two bytes
    step(0,0,1,0,2'b11,16'h5A6B,"R6 latch");
    step(1,1,0,0,2'b11,16'h0000,"R6 lo");
    step(1,0,0,0,2'b11,16'hFFFF,"R6 other");
    step(1,0,0,0,2'b11,16'hFFFF,"R9 other");
    step(1,1,0,0,2'b11,16'h7777,"R6 hi");
    step(1,1,0,0,2'b11,16'h7788,"R6 released");
    step(1,1,0,0,2'b11,16'h7788,"R6 released hi");
    // R5 low only
    step(0,0,0,1,2'b01,16'h0000,"R5 reprog lo");
    step(0,0,1,0,2'b01,16'hABCD,"R5 latch lo");
    step(1,1,0,0,2'b01,16'h1357,"R5 lo held");
    step(1,1,0,0,2'b01,16'h2468,"R5 lo live");
    // R5 high only
    step(0,0,0,1,2'b10,16'h0000,"R5 reprog hi");
    step(0,0,1,0,2'b10,16'hFEDC,"R5 latch hi");
    step(1,1,0,0,2'b10,16'h1357,"R5 hi held");
    step(1,1,0,0,2'b10,16'h2468,"R5 hi live");
    // R5 code 00 behaves as low only
    step(0,0,0,1,2'b00,16'h0000,"R5 reprog 00");
    step(0,0,1,0,2'b00,16'h9911,"R5 latch 00");
    step(1,1,0,0,2'b00,16'h0202,"R5 00 held");
    step(1,1,0,0,2'b00,16'h0303,"R5 00 live");
    // R7 reprog clears hold and pointer, wins over latch
    step(0,0,0,1,2'b11,16'h0000,"R7 reprog");
    step(0,0,1,0,2'b11,16'h4242,"R7 latch");
    step(1,1,0,0,2'b11,16'h0000,"R7 lo");
    step(0,0,1,1,2'b11,16'h6161,"R7 reprog+latch");
    step(1,1,0,0,2'b11,16'h8899,"R7 lo live");
    step(1,1,0,0,2'b11,16'h8899,"R7 hi live");
    // R8 latch coinciding with final read
    step(0,0,1,0,2'b11,16'h1020,"R8 latch");
    step(1,1,0,0,2'b11,16'h3040,"R8 lo");
    step(1,1,1,0,2'b11,16'h5060,"R8 hi+latch");
    step(1,1,0,0,2'b11,16'h7080,"R8 new lo");
    step(1,1,0,0,2'b11,16'h90A0,"R8 new hi");
    step(1,1,0,0,2'b11,16'hB0C0,"R8 released");
    // R10 latch between bytes: high byte comes first
    step(1,1,0,0,2'b11,16'hD0E0,"R10 lo live");
    step(0,0,1,0,2'b11,16'hAB12,"R10 latch");
    step(1,1,0,0,2'b11,16'h0000,"R10 hi held");
    step(1,1,0,0,2'b11,16'h0000,"R10 lo released");
    step(0,0,0,0,2'b11,16'h0000,"R9 end");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule